// File: doc/BRIEF.md
# Phase-Sampled External Event Counter

This block counts rising edges arriving on an external pin that has no timing relationship to the system clock. The system clock is grouped into instruction cycles of four phases, Q1 to Q4, produced by a small phase sequencer. The pin can be routed through an optional power-of-two prescaler, which is a ripple counter clocked directly by the pin. The prescaler output, or the raw pin, then passes through a two-flop synchronizer. After that it is captured only on the Q2 and Q4 phases.

Once a low-to-high change of the captured level has been seen, the 8-bit count advances on the clock edge that opens Q4. Software-style control comes from three inputs. A load port writes a new count, clears the prescaler and masks edge detection for two instruction cycles. A sticky overflow flag records a wrap from the maximum count to zero and stays set until a clear input is pulsed.

Sampling twice per instruction cycle means any high or low interval of at least two system-clock periods is seen at least once. Pulses of that width or wider are therefore never lost.

Top module: `evc_event_counter`

## Requirements
- R1: The phase sequencer holds Q1 (code 0) during reset. It then advances by one phase per system clock in the order Q1, Q2, Q3, Q4 (codes 0 to 3) and wraps back to Q1.
- R2: With the prescaler off, every high pulse of 2, 3 or 6 system-clock periods, separated by low gaps of at least 2 periods, raises the count by exactly one, wherever the pulse falls relative to the phases.
- R3: The count changes by increment only on the clock edge that ends Q3, so after an increment the phase is Q4.
- R4: With `pre_en` low, the pin feeds the synchronizer directly and each pulse on the pin is one event.
- R5: With `pre_en` high, `pre_sel` picks the ratio: 0 gives 1:2, 1 gives 1:4, and 2 or 3 give 1:8. After a prescaler clear, the number of counted events after n pin rising edges is floor((n + r/2) / r) for ratio r.
- R6: A `load` pulse makes the count equal `load_val` on the next clock and clears the prescaler. If an increment falls on the same edge, the load value wins and the pending event is discarded.
- R7: During the eight system clocks after a load edge, a rising level on the pin is not treated as an edge, and that pulse is never counted.
- R8: An increment from 0xFF gives 0x00 and sets `ovf`. A load of any value never sets `ovf`.
- R9: `ovf` stays set until `ovf_clr` is pulsed. If a wrap and `ovf_clr` fall on the same edge, `ovf` ends up set.
- R10: Reset drives the count to 0x00 and `ovf` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 1 | Asynchronous external event pin |
| pre_en | input | 1 | Routes the pin through the prescaler when high |
| pre_sel | input | 2 | Prescaler ratio code (0: 1:2, 1: 1:4, 2/3: 1:8) |
| load | input | 1 | Load strobe for the count; also clears the prescaler |
| load_val | input | 8 | Value written by `load` |
| ovf_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current event count |
| ovf | output | 1 | Sticky wrap flag |

## Verification
Two pairs of functions can land on the same clock edge, and both collisions are provoked on purpose. The first is a pending increment with a load. The second is a wrap-driven overflow set with an overflow clear.

The bench keeps its own model of the phase, counted from reset release. It raises the pin just before a Q1 edge, and from that it knows the increment will land exactly six edges later. It places the `load` or `ovf_clr` strobe on that edge. It then expects either the load value with no later increment, or a zero count with the flag still set.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // Number of system-clock phases in one instruction cycle
    localparam int INSTR_PHASES = 4;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    // Edge-detector state carried by the sampler
    typedef struct packed {
        logic level;    // last phase-qualified sample
        logic pending;  // rising edge seen, increment not yet applied
    } edge_state_t;

    function automatic phase_e next_phase(phase_e p);
        return phase_e'(2'(int'(p) + 1));
    endfunction

    function automatic logic is_sample_phase(phase_e p);
        return (p == PH_Q2) || (p == PH_Q4);
    endfunction

endpackage

// File: rtl/evc_phase_seq.sv
module evc_phase_seq
    import evc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_Q1;
        end else begin
            phase <= next_phase(phase);
        end
    end

endmodule

// File: rtl/evc_prescaler.sv
module evc_prescaler #(
    parameter int STAGES = 3,
    parameter int SEL_W  = 2
) (
    input  logic             ext_in,
    input  logic             clr,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             pre_out
);

    localparam int TAP_W = (STAGES > 1) ? $clog2(STAGES) : 1;

    logic [STAGES-1:0] div_q;
    logic [TAP_W-1:0]  tap;

    // Ripple-style divider clocked by the pin itself; cleared asynchronously
    // from a registered system-domain strobe.
    always_ff @(posedge ext_in or posedge clr) begin
        if (clr) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Codes beyond the last stage saturate to the slowest ratio
    always_comb begin
        if (int'(sel) >= STAGES) begin
            tap = TAP_W'(STAGES - 1);
        end else begin
            tap = TAP_W'(sel);
        end
    end

    assign pre_out = en ? div_q[tap] : ext_in;

endmodule

// File: rtl/evc_sampler.sv
module evc_sampler
    import evc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SUP_CLKS    = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    input  logic   async_in,
    input  logic   load,
    output logic   pend
);

    localparam int SUP_W = $clog2(SUP_CLKS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    edge_state_t            st;
    logic [SUP_W-1:0]       sup_q;
    logic                   sync_lvl;
    logic                   rise;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= 1'b0;
                else     sync_q[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign sync_lvl = sync_q[SYNC_STAGES-1];
    assign rise     = is_sample_phase(phase) && sync_lvl && !st.level
                      && (sup_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            sup_q <= '0;
        end else begin
            if (is_sample_phase(phase)) begin
                st.level <= sync_lvl;
            end
            if (load) begin
                st.pending <= 1'b0;
                sup_q      <= SUP_W'(SUP_CLKS);
            end else begin
                if (sup_q != '0) begin
                    sup_q <= sup_q - 1'b1;
                end
                if (phase == PH_Q3) begin
                    st.pending <= 1'b0;
                end else if (rise) begin
                    st.pending <= 1'b1;
                end
            end
        end
    end

    assign pend = st.pending;

endmodule

// File: rtl/evc_event_counter.sv
module evc_event_counter
    import evc_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int PRE_STAGES  = 3,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int SUP_CYCLES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_in,
    input  logic             pre_en,
    input  logic [SEL_W-1:0] pre_sel,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] count,
    output logic             ovf
);

    localparam int SUP_CLKS = SUP_CYCLES * INSTR_PHASES;

    phase_e phase;
    logic   pre_out;
    logic   pre_clr_q;
    logic   pend;
    logic   inc;

    evc_phase_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    evc_prescaler #(
        .STAGES (PRE_STAGES),
        .SEL_W  (SEL_W)
    ) u_pre (
        .ext_in  (ext_in),
        .clr     (pre_clr_q),
        .en      (pre_en),
        .sel     (pre_sel),
        .pre_out (pre_out)
    );

    evc_sampler #(
        .SYNC_STAGES (SYNC_STAGES),
        .SUP_CLKS    (SUP_CLKS)
    ) u_smp (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .async_in (pre_out),
        .load     (load),
        .pend     (pend)
    );

    assign inc = pend && (phase == PH_Q3);

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            ovf       <= 1'b0;
            pre_clr_q <= 1'b1;
        end else begin
            pre_clr_q <= load;
            if (load) begin
                count <= load_val;
            end else if (inc) begin
                count <= count + 1'b1;
            end
            if (!load && inc && (count == '1)) begin
                ovf <= 1'b1;
            end else if (ovf_clr) begin
                ovf <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/evc_event_counter_chk.sv
module evc_event_counter_chk #(
    parameter int WIDTH    = 8,
    parameter int SUP_CLKS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic [WIDTH-1:0] load_val,
    input logic             ovf_clr,
    input logic [WIDTH-1:0] count,
    input logic             ovf,
    input logic [1:0]       phase,
    input logic             pend
);

    localparam int SL_W = $clog2(SUP_CLKS + 1);

    logic [SL_W-1:0] since_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_load <= SL_W'(SUP_CLKS);
        end else if (load) begin
            since_load <= '0;
        end else if (since_load < SL_W'(SUP_CLKS)) begin
            since_load <= since_load + 1'b1;
        end
    end

    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase == 2'($past(phase) + 2'd1));

    // R3
    inc_on_q3_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && phase != 2'd2) |=> $stable(count));

    // R6
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));

    // R7
    load_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && since_load < SL_W'(SUP_CLKS)) |=> $stable(count));

    // R8
    wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && pend && phase == 2'd2 && count == '1) |=> (count == '0 && ovf));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !(pend && phase == 2'd2 && count == '1 && !load)) |=> !ovf);

endmodule

bind evc_event_counter evc_event_counter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .ovf_clr  (ovf_clr),
    .count    (count),
    .ovf      (ovf),
    .phase    (phase),
    .pend     (pend)
);

// File: tb/tb_evc_event_counter.sv
module tb_evc_event_counter;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_in = 1'b0;
    logic       pre_en = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic       load = 1'b0;
    logic [7:0] load_val = 8'd0;
    logic       ovf_clr = 1'b0;
    logic [7:0] count;
    logic       ovf;

    always #2 clk = ~clk;

    evc_event_counter dut (
        .clk      (clk),
        .rst      (rst),
        .ext_in   (ext_in),
        .pre_en   (pre_en),
        .pre_sel  (pre_sel),
        .load     (load),
        .load_val (load_val),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .ovf      (ovf)
    );

    typedef struct {
        logic [7:0] val;
        bit         is_load;
        string      tag;
    } item_t;

    item_t      q[$];
    int         checks = 0;
    int         errors = 0;
    logic [1:0] ph = 2'd0;
    logic [7:0] exp_cnt = 8'd0;
    logic [7:0] prev_cnt = 8'd0;
    bit         mon_on = 1'b0;
    bit         done = 1'b0;

    // Phase model: Q1 in reset, one step per clock afterwards
    always @(posedge clk) begin
        if (rst) ph <= 2'd0;
        else     ph <= ph + 2'd1;
    end

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic push_exp(logic [7:0] v, bit is_ld, string tag);
        item_t it;
        it.val = v;
        it.is_load = is_ld;
        it.tag = tag;
        q.push_back(it);
        exp_cnt = v;
    endtask

    // Monitor: every change of the count must match the next expected item
    always @(negedge clk) begin
        item_t it;
        if (mon_on && count !== prev_cnt) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "unexpected count change", int'(count), int'(prev_cnt));
            end else begin
                it = q.pop_front();
                check(count == it.val, it.tag, "count value", int'(count), int'(it.val));
                if (!it.is_load)
                    check(ph == 2'd3, "R1/R3", "phase after increment", int'(ph), 3);
            end
            prev_cnt = count;
        end
    end

    task automatic do_load(logic [7:0] v, string tag);
        @(negedge clk);
        if (v != exp_cnt) push_exp(v, 1'b1, tag);
        load = 1'b1;
        load_val = v;
        @(negedge clk);
        load = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic set_mode(bit en, logic [1:0] sel, logic [7:0] v, string tag);
        @(negedge clk);
        pre_en = en;
        pre_sel = sel;
        if (v != exp_cnt) push_exp(v, 1'b1, tag);
        load = 1'b1;
        load_val = v;
        @(negedge clk);
        load = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse(int w, int g, bit counts, string tag);
        int off;
        off = $urandom_range(0, 3);
        repeat (off + 1) @(negedge clk);
        #1;
        if (counts) push_exp(8'(exp_cnt + 8'd1), 1'b0, tag);
        ext_in = 1'b1;
        #(w * 4);
        ext_in = 1'b0;
        #(g * 4);
    endtask

    task automatic drain(string tag);
        repeat (30) @(negedge clk);
        check(q.size() == 0, tag, "events still outstanding", q.size(), 0);
        check(count == exp_cnt, tag, "final count", int'(count), int'(exp_cnt));
    endtask

    // Rise the pin before a Q1 edge; the increment lands six edges later,
    // where a load or an overflow clear is placed.
    task automatic aligned(bit do_ld, bit do_clr, logic [7:0] v, string tag);
        do @(negedge clk); while (ph != 2'd0);
        #1;
        if (do_ld) push_exp(v, 1'b1, tag);
        else       push_exp(8'(exp_cnt + 8'd1), 1'b0, tag);
        ext_in = 1'b1;
        repeat (6) @(negedge clk);
        load = do_ld;
        load_val = v;
        ovf_clr = do_clr;
        @(negedge clk);
        load = 1'b0;
        ovf_clr = 1'b0;
        repeat (4) @(negedge clk);
        ext_in = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R10
        check(count == 8'd0, "R10", "count in reset", int'(count), 0);
        check(ovf == 1'b0, "R10", "ovf in reset", int'(ovf), 0);
        rst = 1'b0;
        prev_cnt = count;
        mon_on = 1'b1;
        repeat (4) @(negedge clk);

        // R2 / R4: raw pin, widths 2, 3, 6 at random offsets
        for (int i = 0; i < 12; i++) begin
            int w;
            w = (i % 3 == 0) ? 2 : ((i % 3 == 1) ? 3 : 6);
            pulse(w, $urandom_range(2, 6), 1'b1, (i < 6) ? "R2" : "R4");
        end
        drain("R2");

        // R5: every ratio code, counted from the prescaler clear
        for (int s = 0; s < 4; s++) begin
            int r;
            int h;
            int n;
            r = (s >= 2) ? 8 : ((s == 1) ? 4 : 2);
            h = r / 2;
            n = 0;
            set_mode(1'b1, 2'(s), 8'(8'h20 + 8'(s * 16)), "R5");
            for (int k = 0; k < 9; k++) begin
                n++;
                pulse(3, 3, ((n + h) / r) > ((n - 1 + h) / r), "R5");
            end
            drain("R5");
        end
        set_mode(1'b0, 2'd0, 8'h40, "R4");

        // R7: pulse right after a load is never counted
        @(negedge clk);
        push_exp(8'h60, 1'b1, "R7");
        load = 1'b1;
        load_val = 8'h60;
        @(negedge clk);
        load = 1'b0;
        #1;
        ext_in = 1'b1;
        #12;
        ext_in = 1'b0;
        drain("R7");
        check(count == 8'h60, "R7", "masked pulse ignored", int'(count), 8'h60);

        // R3: increment placement with a phase-aligned pulse
        aligned(1'b0, 1'b0, 8'h00, "R3");
        drain("R3");

        // R6: load on the same edge as a pending increment
        aligned(1'b1, 1'b0, 8'h55, "R6");
        drain("R6");
        check(count == 8'h55, "R6", "load wins over increment", int'(count), 8'h55);

        // R8: wrap sets overflow
        check(ovf == 1'b0, "R8", "ovf before wrap", int'(ovf), 0);
        do_load(8'hFE, "R8");
        check(ovf == 1'b0, "R8", "load does not set ovf", int'(ovf), 0);
        pulse(3, 3, 1'b1, "R8");
        pulse(3, 3, 1'b1, "R8");
        drain("R8");
        check(ovf == 1'b1, "R8", "ovf after wrap", int'(ovf), 1);

        // R9: sticky, then cleared
        repeat (20) @(negedge clk);
        check(ovf == 1'b1, "R9", "ovf stays set", int'(ovf), 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(ovf == 1'b0, "R9", "ovf cleared", int'(ovf), 0);

        // R9: wrap and clear on the same edge
        do_load(8'hFF, "R9");
        aligned(1'b0, 1'b1, 8'h00, "R9");
        drain("R9");
        check(ovf == 1'b1, "R9", "set wins over clear", int'(ovf), 1);
        check(count == 8'h00, "R9", "count after wrap", int'(count), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule